// File: doc/BRIEF.md
# Remote Bitbang JTAG Command Decoder

This block is the hardware end of a character-based JTAG debug link. A host sends single ASCII characters. The block turns each one into a change on four registered JTAG pin outputs (clock, mode select, data in and test reset), or into a one-byte reply that carries the level of the JTAG data-out pin. The characters arrive on a valid/ready byte stream, and replies leave on a second valid/ready stream. The block never alters a pin on its own: every level stays as the last command left it.

Besides pin commands, the block handles four other kinds of character. A read character samples the data-out pin. Two blink characters are accepted and do nothing. A quit character produces a one-cycle session-end pulse. Any other character produces a one-cycle unknown-command pulse. While a reply byte is waiting and the consumer has not taken it, the block stops accepting input, so no reply is ever lost or overwritten.

Top module: `rbb_jtag_decoder`

## Requirements
- R1: A byte from 0x30 to 0x37 ('0' to '7') is a pin command with value v = byte - 0x30. On the clock after it is accepted, the clock pin equals v bit 2, the mode-select pin equals v bit 1 and the data-in pin equals v bit 0, all three together. The reset pin does not change.
- R2: A byte from 0x72 to 0x75 ('r' to 'u') sets the reset pin to bit 1 of (byte - 0x72): 'r' and 's' drive 0, and 't' and 'u' drive 1. The other pins do not change, and no unknown-command pulse is raised.
- R3: Byte 0x52 ('R') produces exactly one reply byte, equal to 0x30 plus the data-out level. The reply is valid on the clock after the command is accepted, and it disappears once it has been taken.
- R4: The data-out level used for a reply is the one present in the cycle the 'R' byte is accepted. Later changes do not affect that reply.
- R5: Byte 0x51 ('Q') raises the session-end pulse for exactly one cycle and leaves every pin unchanged.
- R6: Bytes 0x42 ('B') and 0x62 ('b') are accepted without changing any pin, without a reply and without any pulse.
- R7: Any byte not covered by R1 to R6 changes no pin, produces no reply and raises the unknown-command pulse for exactly one cycle.
- R8: At most one byte is consumed per clock. Input ready is low while a reply is valid and not being taken, and a byte offered during that time has no effect.
- R9: A reply that is not taken stays valid with an unchanged byte value.
- R10: Synchronous reset drives all four pins to 0, discards any pending reply and clears both pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command byte present |
| cmd_ready | output | 1 | Block can take a command byte |
| cmd_byte | input | 8 | ASCII command byte |
| jtag_tdo | input | 1 | Sampled JTAG data-out level |
| jtag_tck | output | 1 | Registered JTAG clock level |
| jtag_tms | output | 1 | Registered JTAG mode-select level |
| jtag_tdi | output | 1 | Registered JTAG data-in level |
| jtag_trst | output | 1 | Registered JTAG test-reset level |
| rsp_valid | output | 1 | Reply byte present |
| rsp_ready | input | 1 | Consumer takes the reply byte |
| rsp_byte | output | 8 | ASCII reply, '0' or '1' |
| quit_pulse | output | 1 | One-cycle session-end strobe |
| bad_cmd_pulse | output | 1 | One-cycle unknown-command strobe |

## Verification
The assertions assume that the consumer holds rsp_ready at a defined level every cycle. They also assume that cmd_byte is defined whenever cmd_valid is high. They do not require cmd_valid to be held while ready is low, because a byte that is refused has no effect in any case.

The stimulus drives every input at the falling edge and keeps all inputs at known values. It leaves a reply untaken across several cycles and offers a pin byte during that stall. This exercises the hold and back-pressure properties under exactly those conditions.

// File: rtl/rbb_pkg.sv
package rbb_pkg;

  localparam int unsigned BYTE_W = 8;

  // character codes the decoder recognises
  localparam logic [BYTE_W-1:0] CH_DIGIT_LO = 8'h30;
  localparam logic [BYTE_W-1:0] CH_DIGIT_HI = 8'h37;
  localparam logic [BYTE_W-1:0] CH_RST_LO   = 8'h72;
  localparam logic [BYTE_W-1:0] CH_RST_HI   = 8'h75;
  localparam logic [BYTE_W-1:0] CH_SAMPLE   = 8'h52;
  localparam logic [BYTE_W-1:0] CH_LED_ON   = 8'h42;
  localparam logic [BYTE_W-1:0] CH_LED_OFF  = 8'h62;
  localparam logic [BYTE_W-1:0] CH_END      = 8'h51;

  typedef enum logic [2:0] {
    KIND_PINS,
    KIND_RESET,
    KIND_SAMPLE,
    KIND_LED,
    KIND_END,
    KIND_BAD
  } cmd_kind_e;

  typedef struct packed {
    logic tck;
    logic tms;
    logic tdi;
    logic trst;
  } pins_t;

endpackage

// File: rtl/rbb_classify.sv
module rbb_classify
  import rbb_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic [W-1:0] code,
  output cmd_kind_e    kind,
  output logic [2:0]   pin_val,
  output logic         trst_val
);

  logic [1:0] rst_ofs;

  always_comb begin
    pin_val  = code[2:0] - CH_DIGIT_LO[2:0];
    rst_ofs  = code[1:0] - CH_RST_LO[1:0];
    trst_val = rst_ofs[1];
  end

  always_comb begin
    if (code >= W'(CH_DIGIT_LO) && code <= W'(CH_DIGIT_HI))
      kind = KIND_PINS;
    else if (code >= W'(CH_RST_LO) && code <= W'(CH_RST_HI))
      kind = KIND_RESET;
    else if (code == W'(CH_SAMPLE))
      kind = KIND_SAMPLE;
    else if (code == W'(CH_LED_ON) || code == W'(CH_LED_OFF))
      kind = KIND_LED;
    else if (code == W'(CH_END))
      kind = KIND_END;
    else
      kind = KIND_BAD;
  end

endmodule

// File: rtl/rbb_pin_hold.sv
module rbb_pin_hold
  import rbb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load_pins,
  input  logic       load_trst,
  input  logic [2:0] pin_val,
  input  logic       trst_val,
  output pins_t      pins
);

  pins_t pins_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pins_q <= '0;
    end else begin
      if (load_pins) begin
        pins_q.tck <= pin_val[2];
        pins_q.tms <= pin_val[1];
        pins_q.tdi <= pin_val[0];
      end
      if (load_trst)
        pins_q.trst <= trst_val;
    end
  end

  assign pins = pins_q;

  // R6
  scan_pins_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_pins)) |->
      $stable({pins_q.tck, pins_q.tms, pins_q.tdi}));

  // R2
  trst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_trst)) |-> $stable(pins_q.trst));

  // R1
  pins_follow_chk: assert property (@(posedge clk) disable iff (rst)
    load_pins |=> ({pins_q.tck, pins_q.tms, pins_q.tdi} == $past(pin_val)));

endmodule

// File: rtl/rbb_reply_slot.sv
module rbb_reply_slot
  import rbb_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         tdo,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_byte,
  output logic         busy
);

  logic         valid_q;
  logic [W-1:0] byte_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      byte_q  <= W'(CH_DIGIT_LO);
    end else if (load) begin
      valid_q <= 1'b1;
      byte_q  <= W'(CH_DIGIT_LO) + W'(tdo);
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid = valid_q;
  assign out_byte  = byte_q;
  assign busy      = valid_q & ~out_ready;

  // R9
  reply_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !out_ready) |=> (valid_q && $stable(byte_q)));

  // R3
  reply_ascii_chk: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> ((byte_q >> 1) == (W'(CH_DIGIT_LO) >> 1)));

  // R4
  reply_sample_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (byte_q[0] == $past(tdo)));

endmodule

// File: rtl/rbb_jtag_decoder.sv
module rbb_jtag_decoder
  import rbb_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic [W-1:0] cmd_byte,
  input  logic         jtag_tdo,
  output logic         jtag_tck,
  output logic         jtag_tms,
  output logic         jtag_tdi,
  output logic         jtag_trst,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [W-1:0] rsp_byte,
  output logic         quit_pulse,
  output logic         bad_cmd_pulse
);

  cmd_kind_e  kind;
  logic [2:0] pin_val;
  logic       trst_val;
  logic       take;
  logic       slot_busy;
  pins_t      pins;
  logic       quit_q;
  logic       bad_q;

  rbb_classify #(.W(W)) u_classify (
    .code     (cmd_byte),
    .kind     (kind),
    .pin_val  (pin_val),
    .trst_val (trst_val)
  );

  assign cmd_ready = ~slot_busy;
  assign take      = cmd_valid & cmd_ready;

  rbb_pin_hold u_pins (
    .clk       (clk),
    .rst       (rst),
    .load_pins (take && kind == KIND_PINS),
    .load_trst (take && kind == KIND_RESET),
    .pin_val   (pin_val),
    .trst_val  (trst_val),
    .pins      (pins)
  );

  rbb_reply_slot #(.W(W)) u_reply (
    .clk       (clk),
    .rst       (rst),
    .load      (take && kind == KIND_SAMPLE),
    .tdo       (jtag_tdo),
    .out_ready (rsp_ready),
    .out_valid (rsp_valid),
    .out_byte  (rsp_byte),
    .busy      (slot_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      quit_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      quit_q <= take && kind == KIND_END;
      bad_q  <= take && kind == KIND_BAD;
    end
  end

  assign jtag_tck      = pins.tck;
  assign jtag_tms      = pins.tms;
  assign jtag_tdi      = pins.tdi;
  assign jtag_trst     = pins.trst;
  assign quit_pulse    = quit_q;
  assign bad_cmd_pulse = bad_q;

  // R5 R7
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({quit_q, bad_q, rsp_valid && !$past(rsp_valid)}));

  // R8
  stall_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (!quit_q && !bad_q));

  // R5
  quit_keeps_pins_chk: assert property (@(posedge clk) disable iff (rst)
    quit_q |-> $stable(pins));

endmodule

// File: tb/test_rbb_jtag_decoder.sv
module test_rbb_jtag_decoder;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [7:0] cmd_byte = 8'h00;
  logic       jtag_tdo = 1'b0;
  logic       jtag_tck, jtag_tms, jtag_tdi, jtag_trst;
  logic       rsp_valid;
  logic       rsp_ready = 1'b0;
  logic [7:0] rsp_byte;
  logic       quit_pulse, bad_cmd_pulse;

  int checks = 0;
  int errors = 0;
  logic [3:0] model;   // {tck, tms, tdi, trst}

  always #10 clk = ~clk;

  rbb_jtag_decoder i_rbb_jtag_decoder (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_byte(cmd_byte), .jtag_tdo(jtag_tdo), .jtag_tck(jtag_tck),
    .jtag_tms(jtag_tms), .jtag_tdi(jtag_tdi), .jtag_trst(jtag_trst),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_byte(rsp_byte),
    .quit_pulse(quit_pulse), .bad_cmd_pulse(bad_cmd_pulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] pins_now();
    return {jtag_tck, jtag_tms, jtag_tdi, jtag_trst};
  endfunction

  task automatic send_byte(input logic [7:0] b, input logic tdo);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_byte = b; jtag_tdo = tdo;
    @(negedge clk);
    cmd_valid = 1'b0; jtag_tdo = ~tdo;
  endtask

  task automatic exercise(input logic [7:0] b);
    logic tdo;
    logic is_pin, is_rst, is_known;
    logic [7:0] ofs;
    tdo      = b[0] ^ b[4];
    is_pin   = (b >= 8'h30 && b <= 8'h37);
    is_rst   = (b >= 8'h72 && b <= 8'h75);
    is_known = is_pin | is_rst | (b == 8'h52) | (b == 8'h42) | (b == 8'h62) | (b == 8'h51);
    if (is_pin) begin
      ofs = b - 8'h30;
      model[3:1] = ofs[2:0];
    end
    if (is_rst) begin
      ofs = b - 8'h72;
      model[0] = ofs[1];
    end
    send_byte(b, tdo);
    if (is_pin)      check("R1 pins from digit", pins_now(), model);
    else if (is_rst) check("R2 trst from letter", pins_now(), model);
    else if (b == 8'h42 || b == 8'h62) check("R6 blink keeps pins", pins_now(), model);
    else if (b == 8'h51) check("R5 quit keeps pins", pins_now(), model);
    else             check("R7 unknown keeps pins", pins_now(), model);
    check("R5 quit pulse", quit_pulse, b == 8'h51);
    check("R7 unknown pulse", bad_cmd_pulse, !is_known);
    check("R3 reply only for read", rsp_valid, b == 8'h52);
    if (b == 8'h52) begin
      check("R3 R4 reply value", rsp_byte, 8'h30 + tdo);
      check("R8 ready low while reply waits", cmd_ready, 1'b0);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_byte = {5'b00110, ~model[3:1]};
      @(negedge clk);
      cmd_valid = 1'b0;
      check("R8 stalled byte ignored", pins_now(), model);
      check("R9 reply held", {rsp_valid, rsp_byte}, {1'b1, 8'h30 + 8'(tdo)});
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      check("R3 single reply byte", rsp_valid, 1'b0);
      check("R8 ready back", cmd_ready, 1'b1);
    end else begin
      @(negedge clk);
      check("R5 R7 pulses last one cycle", {quit_pulse, bad_cmd_pulse}, 2'b00);
      check("R6 no reply", rsp_valid, 1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model = 4'b0000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R10 reset pins", pins_now(), 4'b0000);
    check("R10 reset reply", rsp_valid, 1'b0);
    check("R10 reset pulses", {quit_pulse, bad_cmd_pulse}, 2'b00);
    check("R8 ready after reset", cmd_ready, 1'b1);

    for (int i = 0; i < 256; i++) exercise(8'(i));
    for (int i = 255; i >= 0; i--) exercise(8'(i));

    // R8 back-to-back bytes, one per clock
    @(negedge clk);
    cmd_valid = 1'b1; cmd_byte = 8'h35;
    @(negedge clk);
    model[3:1] = 3'b101;
    check("R8 first of pair", pins_now(), model);
    cmd_byte = 8'h32;
    @(negedge clk);
    cmd_valid = 1'b0;
    model[3:1] = 3'b010;
    check("R8 second of pair", pins_now(), model);

    // R10 reset discards pending reply
    send_byte(8'h52, 1'b1);
    check("R3 pending before reset", rsp_valid, 1'b1);
    send_byte(8'h74, 1'b0);
    check("R8 trst blocked while stalled", jtag_trst, model[0]);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10 reply discarded", rsp_valid, 1'b0);
    check("R10 pins cleared", pins_now(), 4'b0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule